// File: doc/BRIEF.md
# DMA External Terminate Sense and Latch

This block watches the shared, active-low termination line of a single-channel DMA transfer sequencer and decides when a request on that line is allowed to stop the transfer. The raw line level is first brought into the clock domain through a short synchroniser. A low level is remembered only while the sequencer is busy. It is acted on at the next S2 state, and it is forgotten if the sequencer falls back to idle before S2 comes round. Because the same line is open drain, the block can also pull it low itself. It does so for the whole of the final transfer, when the internal word count is about to roll past zero.

A small state-stepping model of the sequencer sits inside the block so that it can be tested on its own. The model leaves idle on a transfer request and steps through S0 and then S1 to S4. At the end of S4 it either returns to S1 for the next transfer or drops to idle. It drops to idle on its last word, on a terminate that has taken effect, or when the request has gone away, as in demand mode.

Top module: `dma_term_sense`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `seq_state_o` becomes 0 (idle), and `term_latched_o`, `term_now_o` and `term_pin_oe_o` all become 0.
- R2: `term_pin_i` passes through two flops before it is used. A low level present before edge k sets `term_latched_o` after edge k+2, provided the sequencer is active at edge k+2.
- R3: A sensed low level is ignored while `seq_state_o` is 0 (idle): `term_latched_o` does not set.
- R4: A sensed low level sets `term_latched_o` when the sequencer is in any non-idle state, and the flag holds until it is cleared.
- R5: `term_now_o` is high for exactly one cycle, in an S2 state (`seq_state_o` = 3) while `term_latched_o` is set. `term_latched_o` is clear after that edge.
- R6: If the sequencer reaches idle while the flag is set, the flag clears on the next edge and `term_now_o` never pulses for it.
- R7: After `term_now_o`, the sequencer finishes the current transfer through S3 (4) and S4 (5) and then goes to idle, even while `xfer_req` is still high.
- R8: In the final transfer, where the word count is zero, `term_pin_oe_o` is high in S1 through S4 (codes 2 to 5) and low at all other times. `term_pin_o` is always 0.
- R9: At the end of S4 the sequencer goes to idle if `xfer_req` is low (demand mode). Terminate pulses that arrive while it is idle between transfers are not recognised.
- R10: State codes are 0 idle, 1 S0, 2 S1, 3 S2, 4 S3, 5 S4. Idle moves to S0 when `xfer_req` is high, and the word count loads from `wc_init` while idle. The order is S0→S1→S2→S3→S4. From S4 the sequencer goes back to S1 if none of R7, R8's last word or R9 applies. The count decrements at each S4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_req | input | 1 | Transfer request from the peripheral |
| wc_init | input | CNT_W | Word count, minus one, loaded while idle |
| term_pin_i | input | 1 | Sensed level of the shared terminate line (low = terminate) |
| seq_state_o | output | 3 | Sequencer state code |
| term_latched_o | output | 1 | Terminate request remembered |
| term_now_o | output | 1 | One-cycle pulse: terminate takes effect |
| term_pin_oe_o | output | 1 | Pull the terminate line low |
| term_pin_o | output | 1 | Data value for the line when driven (always 0) |

## Verification
Some rules are checked by the assertions on every cycle. Idle always clears the flag. The flag only rises out of an active state. The terminate pulse lasts one cycle and clears the flag. An accepted terminate always runs S3, S4 and then idle. The line drive never appears in idle or S0. Other behaviour can only be shown by the bench's scenarios against its reference model. These are the exact three-edge delay through the synchroniser, pulses lost between demand-mode transfers, and a flag discarded because the request dropped after S2. They also include the drive window tied to a zero word count and the return from S4 to S1 in a multi-word run.

// File: rtl/dma_term_pkg.sv
// Package: shared sequencer state encoding for the terminate logic.
// Assumes a single-channel sequencer with six states.
package dma_term_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_S0   = 3'd1,
        SQ_S1   = 3'd2,
        SQ_S2   = 3'd3,
        SQ_S3   = 3'd4,
        SQ_S4   = 3'd5
    } seq_st_t;
endpackage

// File: rtl/term_sync.sv
// Module: multi-stage synchroniser for the raw terminate line level.
// Assumes the line idles high; every stage resets to 1 (released).
module term_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the asynchronous line
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_q[0] <= 1'b1;
                    else        stg_q[0] <= din;
                end
            end else begin : g_next
                // Later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_q[g] <= 1'b1;
                    else        stg_q[g] <= stg_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/term_latch.sv
// Module: remembers a sensed terminate while the sequencer is active and
// fires it at the next S2. Assumes sensed_low is already synchronous.
// Clearing (idle or firing) wins over setting in the same cycle.
module term_latch
    import dma_term_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sensed_low,
    input  seq_st_t state,
    output logic    latched,
    output logic    fire
);
    logic active;

    assign active = (state != SQ_IDLE);
    assign fire   = latched && (state == SQ_S2);

    // Latch: clear on idle or on firing, else set on a sensed low while active
    always_ff @(posedge clk) begin
        if (!rst_n)                  latched <= 1'b0;
        else if (!active || fire)    latched <= 1'b0;
        else if (sensed_low)         latched <= 1'b1;
    end
endmodule

// File: rtl/xfer_seq_model.sv
// Module: state-stepping model of a single-channel transfer sequencer.
// Assumes wc_init holds the word count minus one; the transfer done with
// count zero is the last. Drives the terminate line for that whole transfer.
module xfer_seq_model
    import dma_term_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] wc_init,
    input  logic             term_fire,
    output seq_st_t          state,
    output logic             drive_oe
);
    seq_st_t          nxt;
    logic [CNT_W-1:0] wc_q;
    logic             abort_q;
    logic             last_word;
    logic             in_xfer;

    assign last_word = (wc_q == '0);
    assign in_xfer   = (state == SQ_S1) || (state == SQ_S2) ||
                       (state == SQ_S3) || (state == SQ_S4);
    assign drive_oe  = last_word && in_xfer;

    // Next-state selection for the stepping model
    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE: nxt = req ? SQ_S0 : SQ_IDLE;
            SQ_S0:   nxt = SQ_S1;
            SQ_S1:   nxt = SQ_S2;
            SQ_S2:   nxt = SQ_S3;
            SQ_S3:   nxt = SQ_S4;
            SQ_S4:   nxt = (last_word || abort_q || !req) ? SQ_IDLE : SQ_S1;
            default: nxt = SQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    // Word counter: load while idle, count down at the end of each transfer
    always_ff @(posedge clk) begin
        if (!rst_n)                 wc_q <= '0;
        else if (state == SQ_IDLE)  wc_q <= wc_init;
        else if (state == SQ_S4)    wc_q <= wc_q - CNT_W'(1);
    end

    // Abort flag: remembers an accepted terminate until the run ends
    always_ff @(posedge clk) begin
        if (!rst_n)                 abort_q <= 1'b0;
        else if (state == SQ_IDLE)  abort_q <= 1'b0;
        else if (term_fire)         abort_q <= 1'b1;
    end
endmodule

// File: rtl/dma_term_sense.sv
// Module: top of the external terminate sense/latch logic with its
// sequencer model. Assumes term_pin_i is the resolved level of the shared
// open-drain line; the line is pulled low when term_pin_oe_o is high.
module dma_term_sense
    import dma_term_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_req,
    input  logic [CNT_W-1:0] wc_init,
    input  logic             term_pin_i,
    output logic [2:0]       seq_state_o,
    output logic             term_latched_o,
    output logic             term_now_o,
    output logic             term_pin_oe_o,
    output logic             term_pin_o
);
    logic    pin_sync;
    logic    fire;
    seq_st_t st;

    term_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (term_pin_i),
        .dout  (pin_sync)
    );

    term_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sensed_low (!pin_sync),
        .state      (st),
        .latched    (term_latched_o),
        .fire       (fire)
    );

    xfer_seq_model #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (xfer_req),
        .wc_init   (wc_init),
        .term_fire (fire),
        .state     (st),
        .drive_oe  (term_pin_oe_o)
    );

    assign seq_state_o = st;
    assign term_now_o  = fire;
    assign term_pin_o  = 1'b0;
endmodule

// File: rtl/dma_term_sense_chk.sv
// Module: property checker for dma_term_sense, attached with bind below.
module dma_term_sense_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] seq_state_o,
    input logic       term_latched_o,
    input logic       term_now_o,
    input logic       term_pin_oe_o
);
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state_o == 3'd0) |=> !term_latched_o); // R6
    AST_SET_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_latched_o) |-> ($past(seq_state_o) != 3'd0)); // R3
    AST_NOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        term_now_o |=> !term_latched_o); // R5
    AST_NOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        term_now_o |=> !term_now_o); // R5
    AST_ABORT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        term_now_o |=> (seq_state_o == 3'd4) ##1 (seq_state_o == 3'd5)
                       ##1 (seq_state_o == 3'd0)); // R7
    AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        term_pin_oe_o |-> (seq_state_o >= 3'd2) && (seq_state_o <= 3'd5)); // R8
    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state_o == 3'd2) |=> (seq_state_o == 3'd3)); // R10
endmodule

bind dma_term_sense dma_term_sense_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .seq_state_o    (seq_state_o),
    .term_latched_o (term_latched_o),
    .term_now_o     (term_now_o),
    .term_pin_oe_o  (term_pin_oe_o)
);

// File: tb/test_dma_term_sense.sv
module test_dma_term_sense;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [CW-1:0] wc_init = '0;
    logic          ext_low = 1'b0;
    logic          pin;
    logic [2:0]    st_o;
    logic          lat_o, now_o, oe_o, pd_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit chk_en = 1'b0;

    always #2.5 clk = ~clk;

    assign pin = !(ext_low || oe_o);

    dma_term_sense #(.CNT_W(CW)) i_dma_term_sense (
        .clk(clk), .rst_n(rst_n), .xfer_req(req), .wc_init(wc_init),
        .term_pin_i(pin), .seq_state_o(st_o), .term_latched_o(lat_o),
        .term_now_o(now_o), .term_pin_oe_o(oe_o), .term_pin_o(pd_o)
    );

    // Reference model built from the requirements
    logic [2:0]    m_st = 3'd0;
    logic [CW-1:0] m_wc = '0;
    logic          m_ab = 1'b0, m_s1 = 1'b1, m_s2 = 1'b1, m_lat = 1'b0;

    function automatic logic f_now(logic [2:0] s, logic l);
        return (s == 3'd3) && l;
    endfunction
    function automatic logic f_oe(logic [2:0] s, logic [CW-1:0] w);
        return (w == '0) && (s >= 3'd2) && (s <= 3'd5);
    endfunction
    function automatic logic [2:0] f_next(logic [2:0] s, logic r, logic lastw, logic ab);
        case (s)
            3'd0: return r ? 3'd1 : 3'd0;
            3'd5: return (lastw || ab || !r) ? 3'd0 : 3'd2;
            default: return s + 3'd1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 3'd0; m_wc <= '0; m_ab <= 1'b0;
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_lat <= 1'b0;
        end else begin
            m_s1 <= !(ext_low || f_oe(m_st, m_wc));
            m_s2 <= m_s1;
            if (m_st == 3'd0 || f_now(m_st, m_lat)) m_lat <= 1'b0;
            else if (!m_s2)                        m_lat <= 1'b1;
            if (m_st == 3'd0)      m_ab <= 1'b0;
            else if (f_now(m_st, m_lat)) m_ab <= 1'b1;
            if (m_st == 3'd0)      m_wc <= wc_init;
            else if (m_st == 3'd5) m_wc <= m_wc - 1'b1;
            m_st <= f_next(m_st, req, m_wc == '0, m_ab);
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (chk_en) begin
            check("state R7 R9 R10", 32'(st_o), 32'(m_st));
            check("latch R2 R3 R4 R6", 32'(lat_o), 32'(m_lat));
            check("now R5", 32'(now_o), 32'(f_now(m_st, m_lat)));
            check("drive R8", 32'(oe_o), 32'(f_oe(m_st, m_wc)));
            check("data R8", 32'(pd_o), 32'd0);
        end
    end

    task automatic wait_state(logic [2:0] s);
        do @(negedge clk); while (st_o != s);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(5 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired R10");
        summary();
    end

    initial begin
        bit saw_now;
        void'($urandom(32'h1d3a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset R1 state", 32'(st_o), 0);
        check("reset R1 latch", 32'(lat_o), 0);
        check("reset R1 drive", 32'(oe_o), 0);
        chk_en = 1'b1;

        // R3: low while idle is ignored
        ext_low = 1'b1;
        repeat (5) @(negedge clk);
        check("R3 idle low ignored", 32'(lat_o), 0);
        ext_low = 1'b0;
        repeat (3) @(negedge clk);

        // R2/R4/R5/R7: pulse in S0, fires at S2 of the next transfer, run ends
        wc_init = 16'd6; req = 1'b1;
        wait_state(3'd1);
        ext_low = 1'b1; @(negedge clk); ext_low = 1'b0;
        @(negedge clk);
        check("R2 not yet latched", 32'(lat_o), 0);
        @(negedge clk);
        check("R4 latched", 32'(lat_o), 1);
        wait_state(3'd3);
        check("R5 pulse at S2", 32'(now_o), 1);
        wait_state(3'd0);
        check("R7 run ended with req high", 32'(st_o), 0);
        req = 1'b0;
        repeat (2) @(negedge clk);

        // R6/R9: latched after S2, request dropped, flag discarded
        wc_init = 16'd9; req = 1'b1;
        wait_state(3'd3);
        ext_low = 1'b1; req = 1'b0;
        @(negedge clk); ext_low = 1'b0;
        saw_now = 1'b0;
        repeat (4) begin @(negedge clk); saw_now |= now_o; end
        check("R9 idle after req drop", 32'(st_o), 0);
        check("R6 latch discarded", 32'(lat_o), 0);
        check("R6 no fire", 32'(saw_now), 0);

        // R8: single-word run drives the line for S1..S4
        wc_init = 16'd0; req = 1'b1;
        wait_state(3'd2);
        check("R8 drive in last transfer", 32'(oe_o), 1);
        req = 1'b0;
        wait_state(3'd0);
        check("R8 drive released", 32'(oe_o), 0);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom % 16 == 0) req = ~req;
            ext_low = ($urandom % 10 == 0);
            if (st_o == 3'd0) wc_init = 16'($urandom % 4);
        end
        ext_low = 1'b0; req = 1'b0;
        repeat (10) @(negedge clk);
        summary();
    end
endmodule